// File: doc/BRIEF.md
# Dual-Compare 8-bit Timer Pair

Two independent 8-bit up-counters share one register bus. Each channel compares its counter against two compare registers on every clock. An equal value sets a sticky status flag, and the flag can raise an interrupt. Depending on the control register, the counter restarts from zero after a match on A or on B, or runs freely and reports each wrap with an overflow flag. Every channel drives one output pin. On a new compare match the pin is held, forced low, forced high or toggled, according to two-bit select fields in the status register.

Counting is paced by a per-channel tick-enable input, which a prescaler outside the block supplies. Registers of the same kind in the two channels sit at neighbouring byte addresses. A 16-bit word access therefore reaches both at once: channel 0 travels in the upper byte and channel 1 in the lower byte. While software writes a compare register, the compare check of that channel is held off for that cycle, so a half-updated value cannot produce a false match. A hardware-standby input returns every register to its reset state.

Top module: `tmr8_pair`

## Requirements
- R1: After a reset, and after any cycle with `hw_standby` high, every counter reads 0x00, both compare registers of both channels read 0xFF, control and status read 0x00, and all pins and interrupt lines are low.
- R2: Register addressing uses `bus_addr[3:1]` to select the kind and `bus_addr[0]` to select the channel. The kinds are 0 counter, 1 compare A, 2 compare B, 3 control and 4 status. A byte access carries its data in bits 7:0. Read data appears on `bus_rdata` in the cycle after the `bus_rd` strobe and shows the register values from before that clock edge.
- R3: A word access (`bus_word` high) ignores `bus_addr[0]`. It writes channel 0 from `bus_wdata[15:8]` and channel 1 from `bus_wdata[7:0]`, and a word read returns the two values in the same byte placement.
- R4: The clock-select field in control bits 2:0 controls counting. When it is nonzero, the counter advances by one in each cycle with its `tick_en` bit high. When it is 0x0, the counter holds. A write to the counter loads the written value and takes precedence over counting.
- R5: When the counter advances by increment from 0xFF to 0x00, the overflow flag (status bit 5) is set.
- R6: A counter equal to compare A sets status bit 6, and a counter equal to compare B sets status bit 7, at the next clock edge. The check runs in every cycle, whether or not the counter is running.
- R7: In a cycle in which either compare register of a channel is written, no compare match of that channel is detected.
- R8: Control bits 4:3 select the clear mode: 01 clears on match A, 10 clears on match B, and 00 or 11 never clears. In a clearing mode, a tick that arrives while the selected match is present loads 0x00 instead of incrementing, and it does not set the overflow flag.
- R9: Writing 0 to a status flag clears it only if that flag was read as 1 since the last status write. Writing 1 leaves the flag unchanged. A set condition in the same cycle as the clear keeps the flag at 1.
- R10: `irq_cmpb`, `irq_cmpa` and `irq_ovf` of a channel equal its flag ANDed with control bit 7, 6 and 5 respectively.
- R11: On a rising compare match the channel's pin follows the select field, status bits 1:0 for match A and bits 3:2 for match B: 00 holds, 01 drives low, 10 drives high and 11 toggles. When both matches rise in the same cycle, the match B field alone decides.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_standby | input | 1 | Hardware standby; while high, it holds all registers at their reset values |
| tick_en | input | 2 | Per-channel count enable from the external prescaler |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | 1 | Word access covering both channels |
| bus_addr | input | 4 | Register address: kind in bits 3:1, channel in bit 0 |
| bus_wdata | input | 2*CW | Write data |
| bus_rdata | output | 2*CW | Read data, registered |
| irq_cmpa | output | 2 | Compare-A interrupt request per channel |
| irq_cmpb | output | 2 | Compare-B interrupt request per channel |
| irq_ovf | output | 2 | Overflow interrupt request per channel |
| tmr_out | output | 2 | Timer output pin per channel |

## Verification
The bench builds the block with the default counter width `CW` = 8. At that width the wrap from 0xFF takes only a few ticks after a counter preload, and the 16-bit word access splits exactly into the two channel bytes. With this width the bench can pass a counter over a compare value in the very cycle a compare register is written, and it can run both clear modes and the reserved mode in short periods. It can also line up equal A and B compare values, so that simultaneous matches test the pin priority.

// File: rtl/tmr8_pkg.sv
// Shared definitions for the dual-compare timer pair: register kinds,
// bit positions inside control and status, and per-channel bus strobes.
// Assumes a data byte of at least eight bits.
package tmr8_pkg;

    localparam int NCH    = 2;   // channels; word access pairs exactly two
    localparam int NKIND  = 5;   // register kinds per channel
    localparam int NFLAG  = 3;   // overflow, match A, match B

    // register kind codes, decoded from bus_addr[3:1]
    localparam logic [2:0] K_CNT  = 3'd0;
    localparam logic [2:0] K_CMPA = 3'd1;
    localparam logic [2:0] K_CMPB = 3'd2;
    localparam logic [2:0] K_CTL  = 3'd3;
    localparam logic [2:0] K_STS  = 3'd4;

    // control register bit positions
    localparam int CTL_IE_B  = 7;
    localparam int CTL_IE_A  = 6;
    localparam int CTL_IE_OV = 5;
    localparam int CTL_CLR   = 3;   // two bits, 4:3
    localparam int CTL_CKS   = 0;   // three bits, 2:0

    // status register: flags sit at FLAG_BASE + index (0 ovf, 1 A, 2 B)
    localparam int STS_FLAG_BASE = 5;
    localparam int STS_SEL_B     = 2;   // two bits, 3:2
    localparam int STS_SEL_A     = 0;   // two bits, 1:0

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_ON_A = 2'b01,
        CLR_ON_B = 2'b10,
        CLR_RSVD = 2'b11
    } clr_mode_e;

    typedef enum logic [1:0] {
        OUT_KEEP   = 2'b00,
        OUT_LOW    = 2'b01,
        OUT_HIGH   = 2'b10,
        OUT_TOGGLE = 2'b11
    } out_sel_e;

    typedef struct packed {
        logic wr_cnt;
        logic wr_cmpa;
        logic wr_cmpb;
        logic wr_ctl;
        logic wr_sts;
        logic rd_sts;
    } chan_strobe_t;

endpackage

// File: rtl/tmr8_regif.sv
// Register bus decode for the timer pair.
// Turns the bus strobes into per-channel write and read strobes, routes the
// write byte of each channel (word access: channel 0 high byte, channel 1 low
// byte), and registers the read data one cycle after the read strobe.
// Assumes no read and write strobe in the same cycle.
module tmr8_regif
    import tmr8_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic                 bus_word,
    input  logic [3:0]           bus_addr,
    input  logic [2*CW-1:0]      bus_wdata,
    input  logic [CW-1:0]        view_i  [NCH][NKIND],
    output chan_strobe_t         stb_o   [NCH],
    output logic [CW-1:0]        wdata_o [NCH],
    output logic [2*CW-1:0]      rdata_o
);

    logic [2:0]    kind;
    logic [NCH-1:0] hit;
    logic [CW-1:0] rv [NCH];
    logic [2*CW-1:0] rd_next;

    assign kind = bus_addr[3:1];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // channel selected by address bit 0, or by any word access
        assign hit[c]     = bus_word || (bus_addr[0] == 1'(c));
        // byte lane of this channel
        assign wdata_o[c] = bus_word ? bus_wdata[(NCH-1-c)*CW +: CW] : bus_wdata[CW-1:0];

        // per-channel strobes
        always_comb begin
            stb_o[c]         = '0;
            stb_o[c].wr_cnt  = bus_wr && hit[c] && (kind == K_CNT);
            stb_o[c].wr_cmpa = bus_wr && hit[c] && (kind == K_CMPA);
            stb_o[c].wr_cmpb = bus_wr && hit[c] && (kind == K_CMPB);
            stb_o[c].wr_ctl  = bus_wr && hit[c] && (kind == K_CTL);
            stb_o[c].wr_sts  = bus_wr && hit[c] && (kind == K_STS);
            stb_o[c].rd_sts  = bus_rd && hit[c] && (kind == K_STS);
        end

        // readback value of the addressed kind for this channel
        always_comb begin
            case (kind)
                K_CNT:   rv[c] = view_i[c][0];
                K_CMPA:  rv[c] = view_i[c][1];
                K_CMPB:  rv[c] = view_i[c][2];
                K_CTL:   rv[c] = view_i[c][3];
                K_STS:   rv[c] = view_i[c][4];
                default: rv[c] = '0;
            endcase
        end

        // R3
        wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({stb_o[c].wr_cnt, stb_o[c].wr_cmpa, stb_o[c].wr_cmpb,
                      stb_o[c].wr_ctl, stb_o[c].wr_sts}));
    end

    // read data: both channels for a word, the addressed one for a byte
    assign rd_next = bus_word ? {rv[0], rv[1]} : {{CW{1'b0}}, rv[bus_addr[0]]};

    // read data register, updated on each read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_o <= '0;
        else if (bus_rd) rdata_o <= rd_next;
    end

endmodule

// File: rtl/tmr8_flag.sv
// One sticky status flag with read-before-clear protection.
// Sets on set_i; a status write with a 0 in its bit clears it only when the
// flag was read as 1 since the previous status write; set wins over clear.
module tmr8_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);

    logic armed;

    // flag and its read-seen marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            armed  <= 1'b0;
        end else begin
            if (set_i)                        flag_o <= 1'b1;
            else if (wr_i && !wbit_i && armed) flag_o <= 1'b0;

            if (wr_i)                 armed <= 1'b0;
            else if (rd_i && flag_o)  armed <= 1'b1;
        end
    end

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R9
    flag_unread_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !armed) |=> flag_o);

endmodule

// File: rtl/tmr8_chan.sv
// One timer channel: counter, two compare registers, control, status flags,
// interrupt requests and the output pin.
// Assumes CW >= 8 (control and status fields occupy bits 7:0).
// The compare check is suppressed in the cycle a compare register is written.
module tmr8_chan
    import tmr8_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  chan_strobe_t stb_i,
    input  logic [CW-1:0] wdata_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cmpa_o,
    output logic [CW-1:0] cmpb_o,
    output logic [CW-1:0] ctl_o,
    output logic [CW-1:0] sts_o,
    output logic          irq_a_o,
    output logic          irq_b_o,
    output logic          irq_ov_o,
    output logic          pin_o
);

    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0]    cnt, cmpa, cmpb;
    logic [7:0]       ctl;
    logic [1:0]       sel_a, sel_b;
    logic             suppress, match_a, match_b, run, clr_hit, wrap;
    logic             mq_a, mq_b, ev_a, ev_b;
    logic [NFLAG-1:0] set_v, flags;
    clr_mode_e        mode;
    out_sel_e         act;

    // compare and counting conditions
    assign suppress = stb_i.wr_cmpa | stb_i.wr_cmpb;
    assign match_a  = (cnt == cmpa) && !suppress;
    assign match_b  = (cnt == cmpb) && !suppress;
    assign run      = tick_i && (ctl[CTL_CKS +: 3] != 3'b000);
    assign mode     = clr_mode_e'(ctl[CTL_CLR +: 2]);

    // selected clear source
    always_comb begin
        case (mode)
            CLR_ON_A: clr_hit = match_a;
            CLR_ON_B: clr_hit = match_b;
            default:  clr_hit = 1'b0;
        endcase
    end

    assign wrap = run && !stb_i.wr_cnt && !clr_hit && (cnt == CNT_MAX);

    // counter: write load, else clear or increment on a tick
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (stb_i.wr_cnt) cnt <= wdata_i;
        else if (run)          cnt <= clr_hit ? '0 : cnt + 1'b1;
    end

    // compare registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmpa <= '1;
            cmpb <= '1;
        end else begin
            if (stb_i.wr_cmpa) cmpa <= wdata_i;
            if (stb_i.wr_cmpb) cmpb <= wdata_i;
        end
    end

    // control register and output-select fields of status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl   <= '0;
            sel_a <= '0;
            sel_b <= '0;
        end else begin
            if (stb_i.wr_ctl) ctl <= wdata_i[7:0];
            if (stb_i.wr_sts) begin
                sel_a <= wdata_i[STS_SEL_A +: 2];
                sel_b <= wdata_i[STS_SEL_B +: 2];
            end
        end
    end

    // sticky flags: index 0 overflow, 1 match A, 2 match B
    assign set_v = {match_b, match_a, wrap};

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        tmr8_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[i]),
            .rd_i   (stb_i.rd_sts),
            .wr_i   (stb_i.wr_sts),
            .wbit_i (wdata_i[STS_FLAG_BASE + i]),
            .flag_o (flags[i])
        );
    end

    // rising-edge memory of each match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mq_a <= 1'b0;
            mq_b <= 1'b0;
        end else begin
            mq_a <= match_a;
            mq_b <= match_b;
        end
    end

    assign ev_a = match_a && !mq_a;
    assign ev_b = match_b && !mq_b;

    // pin action: match B field wins when both rise
    always_comb begin
        act = OUT_KEEP;
        if (ev_b)      act = out_sel_e'(sel_b);
        else if (ev_a) act = out_sel_e'(sel_a);
    end

    // output pin register
    always_ff @(posedge clk) begin
        if (!rst_n) pin_o <= 1'b0;
        else begin
            case (act)
                OUT_LOW:    pin_o <= 1'b0;
                OUT_HIGH:   pin_o <= 1'b1;
                OUT_TOGGLE: pin_o <= ~pin_o;
                default:    pin_o <= pin_o;
            endcase
        end
    end

    assign cnt_o    = cnt;
    assign cmpa_o   = cmpa;
    assign cmpb_o   = cmpb;
    assign ctl_o    = CW'(ctl);
    assign sts_o    = CW'({flags[2], flags[1], flags[0], 1'b0, sel_b, sel_a});
    assign irq_a_o  = flags[1] && ctl[CTL_IE_A];
    assign irq_b_o  = flags[2] && ctl[CTL_IE_B];
    assign irq_ov_o = flags[0] && ctl[CTL_IE_OV];

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !stb_i.wr_cnt && !clr_hit) |=> (cnt == $past(cnt) + 1'b1));

    // R8
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && clr_hit && !stb_i.wr_cnt) |=> (cnt == '0 && !$rose(flags[0])));

    // R5
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0 && flags[0]));

    // R7
    suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (suppress && !flags[1] && !flags[2]) |=> (!flags[1] && !flags[2]));

    // R11
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_a && !ev_b) |=> $stable(pin_o));

endmodule

// File: rtl/tmr8_pair.sv
// Top of the dual-compare timer pair: bus decode plus two channels.
// hw_standby acts as a synchronous reset of the whole block while high.
module tmr8_pair
    import tmr8_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw_standby,
    input  logic [1:0]      tick_en,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic            bus_word,
    input  logic [3:0]      bus_addr,
    input  logic [2*CW-1:0] bus_wdata,
    output logic [2*CW-1:0] bus_rdata,
    output logic [1:0]      irq_cmpa,
    output logic [1:0]      irq_cmpb,
    output logic [1:0]      irq_ovf,
    output logic [1:0]      tmr_out
);

    logic          blk_rst_n;
    chan_strobe_t  stb  [NCH];
    logic [CW-1:0] wdat [NCH];
    logic [CW-1:0] view [NCH][NKIND];

    assign blk_rst_n = rst_n && !hw_standby;

    tmr8_regif #(.CW(CW)) u_regif (
        .clk       (clk),
        .rst_n     (blk_rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .view_i    (view),
        .stb_o     (stb),
        .wdata_o   (wdat),
        .rdata_o   (bus_rdata)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        tmr8_chan #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst_n    (blk_rst_n),
            .tick_i   (tick_en[c]),
            .stb_i    (stb[c]),
            .wdata_i  (wdat[c]),
            .cnt_o    (view[c][0]),
            .cmpa_o   (view[c][1]),
            .cmpb_o   (view[c][2]),
            .ctl_o    (view[c][3]),
            .sts_o    (view[c][4]),
            .irq_a_o  (irq_cmpa[c]),
            .irq_b_o  (irq_cmpb[c]),
            .irq_ov_o (irq_ovf[c]),
            .pin_o    (tmr_out[c])
        );
    end

    // R1
    standby_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_standby |=> (tmr_out == 2'b00 && irq_cmpa == 2'b00 && irq_cmpb == 2'b00 && irq_ovf == 2'b00));

endmodule

// File: tb/tmr8_pair_bench.sv
`timescale 1ns/1ps
module tmr8_pair_bench;

    logic        clk = 1'b0;
    logic        rst_n, hw_standby, bus_wr, bus_rd, bus_word;
    logic [1:0]  tick_en;
    logic [3:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [1:0]  irq_cmpa, irq_cmpb, irq_ovf, tmr_out;

    always #4 clk = ~clk;   // 125 MHz

    tmr8_pair u_tmr8_pair (
        .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .tick_en(tick_en),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_word(bus_word), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_cmpa(irq_cmpa),
        .irq_cmpb(irq_cmpb), .irq_ovf(irq_ovf), .tmr_out(tmr_out)
    );

    int n_chk = 0, n_fail = 0;
    bit chk_on = 0;
    string cur_tag = "none", rd_tag = "none";
    bit rd_pend = 0;
    int exp_rd = 0;

    // behavioural reference state
    int m_cnt[2], m_cmpa[2], m_cmpb[2], m_ctl[2], m_sela[2], m_selb[2];
    int m_flag[2][3], m_arm[2][3], m_pin[2], m_mqa[2], m_mqb[2];

    function automatic int reg_val(int k, int c);
        case (k)
            0: return m_cnt[c];
            1: return m_cmpa[c];
            2: return m_cmpb[c];
            3: return m_ctl[c];
            4: return (m_flag[c][2] << 7) | (m_flag[c][1] << 6) | (m_flag[c][0] << 5)
                      | (m_selb[c] << 2) | m_sela[c];
            default: return 0;
        endcase
    endfunction

    task automatic check(int act, int exp, string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // reference model, one step per clock from the requirements
    always @(posedge clk) begin
        int kind, val, hit, wc, wa, wb, wt, ws, rdh, ma, mb, run, mode, clr, ncnt;
        int setv[3], act, nf;
        kind = int'(bus_addr[3:1]);
        if (bus_rd) begin
            exp_rd  = bus_word ? ((reg_val(kind, 0) << 8) | reg_val(kind, 1))
                               : reg_val(kind, int'(bus_addr[0]));
            rd_tag  = cur_tag;
            rd_pend = 1;
        end else rd_pend = 0;
        for (int c = 0; c < 2; c++) begin
            if (!rst_n || hw_standby) begin
                m_cnt[c] = 0; m_cmpa[c] = 255; m_cmpb[c] = 255; m_ctl[c] = 0;
                m_sela[c] = 0; m_selb[c] = 0; m_pin[c] = 0; m_mqa[c] = 0; m_mqb[c] = 0;
                for (int i = 0; i < 3; i++) begin m_flag[c][i] = 0; m_arm[c][i] = 0; end
            end else begin
                hit = (bus_word || int'(bus_addr[0]) == c) ? 1 : 0;
                val = bus_word ? (c == 0 ? int'(bus_wdata[15:8]) : int'(bus_wdata[7:0]))
                               : int'(bus_wdata[7:0]);
                wc = bus_wr && hit && kind == 0;
                wa = bus_wr && hit && kind == 1;
                wb = bus_wr && hit && kind == 2;
                wt = bus_wr && hit && kind == 3;
                ws = bus_wr && hit && kind == 4;
                rdh = bus_rd && hit && kind == 4;
                ma = (m_cnt[c] == m_cmpa[c]) && !(wa || wb);
                mb = (m_cnt[c] == m_cmpb[c]) && !(wa || wb);
                run = tick_en[c] && ((m_ctl[c] & 7) != 0);
                mode = (m_ctl[c] >> 3) & 3;
                clr = (mode == 1 && ma) || (mode == 2 && mb);
                ncnt = m_cnt[c];
                setv[0] = 0;
                if (wc) ncnt = val;
                else if (run) begin
                    if (clr) ncnt = 0;
                    else begin
                        ncnt = (m_cnt[c] + 1) % 256;
                        setv[0] = (m_cnt[c] == 255);
                    end
                end
                setv[1] = ma; setv[2] = mb;
                for (int i = 0; i < 3; i++) begin
                    nf = m_flag[c][i];
                    if (setv[i]) nf = 1;
                    else if (ws && !((val >> (5 + i)) & 1) && m_arm[c][i]) nf = 0;
                    if (ws) m_arm[c][i] = 0;
                    else if (rdh && m_flag[c][i]) m_arm[c][i] = 1;
                    m_flag[c][i] = nf;
                end
                act = 0;
                if (mb && !m_mqb[c]) act = m_selb[c];
                else if (ma && !m_mqa[c]) act = m_sela[c];
                if (act == 1) m_pin[c] = 0;
                else if (act == 2) m_pin[c] = 1;
                else if (act == 3) m_pin[c] = 1 - m_pin[c];
                m_mqa[c] = ma; m_mqb[c] = mb;
                m_cnt[c] = ncnt;
                if (wa) m_cmpa[c] = val;
                if (wb) m_cmpb[c] = val;
                if (wt) m_ctl[c] = val;
                if (ws) begin m_sela[c] = val & 3; m_selb[c] = (val >> 2) & 3; end
            end
        end
    end

    // compare outputs against the model away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            for (int c = 0; c < 2; c++) begin
                check(int'(tmr_out[c]), m_pin[c], "R11 output pin");
                check(int'(irq_cmpa[c]), m_flag[c][1] & ((m_ctl[c] >> 6) & 1), "R10 irq A");
                check(int'(irq_cmpb[c]), m_flag[c][2] & ((m_ctl[c] >> 7) & 1), "R10 irq B");
                check(int'(irq_ovf[c]),  m_flag[c][0] & ((m_ctl[c] >> 5) & 1), "R10 irq ovf");
            end
            if (rd_pend) check(int'(bus_rdata), exp_rd, rd_tag);
        end
    end

    function automatic logic [3:0] adr(int kind, int ch);
        return 4'(kind * 2 + ch);
    endfunction

    task automatic wr(logic [3:0] a, int d, bit word, string tag);
        cur_tag = tag; bus_addr = a; bus_wdata = 16'(d); bus_word = word; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_word = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, bit word, string tag);
        cur_tag = tag; bus_addr = a; bus_word = word; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_word = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // watchdog
    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; hw_standby = 1'b0; tick_en = 2'b00; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_word = 1'b0; bus_addr = '0; bus_wdata = '0;
        idle(3);
        chk_on = 1;
        rst_n = 1'b1;

        // R1 reset values of every register
        for (int c = 0; c < 2; c++)
            for (int k = 0; k < 5; k++) rd(adr(k, c), 0, "R1 reset value");

        // R2 byte access
        wr(adr(1, 1), 'h05, 0, "R2");
        rd(adr(1, 1), 0, "R2 byte readback");
        rd(adr(1, 0), 0, "R2 other channel untouched");

        // R3 word access
        wr(adr(2, 0), 'h1234, 1, "R3");
        rd(adr(2, 0), 1, "R3 word read");
        rd(adr(2, 1), 0, "R3 low byte to channel 1");
        rd(adr(2, 0), 0, "R3 high byte to channel 0");

        // R4 counting, stopping, pacing and loading
        wr(adr(3, 0), 'h01, 0, "R4");
        tick_en = 2'b11; idle(5); tick_en = 2'b00;
        rd(adr(0, 0), 0, "R4 count after five ticks");
        rd(adr(0, 1), 0, "R4 stopped channel holds");
        for (int i = 0; i < 6; i++) begin tick_en[0] = 1'(i % 2); @(negedge clk); end
        tick_en = 2'b00;
        rd(adr(0, 0), 0, "R4 paced by tick");
        wr(adr(0, 0), 'h80, 0, "R4 load");
        rd(adr(0, 0), 0, "R4 loaded value");

        // R5 overflow with its interrupt enabled (R10)
        wr(adr(3, 0), 'h21, 0, "R10");
        wr(adr(0, 0), 'hFD, 0, "R5");
        tick_en = 2'b01; idle(5); tick_en = 2'b00;
        rd(adr(4, 0), 0, "R5 overflow flag");

        // R6 compare flags
        wr(adr(1, 0), 'h10, 0, "R6");
        wr(adr(0, 0), 'h0E, 0, "R6");
        wr(adr(3, 0), 'hC1, 0, "R10");
        tick_en = 2'b01; idle(4); tick_en = 2'b00;
        rd(adr(4, 0), 0, "R6 match flags");

        // R9 read-before-clear; counter rests on compare B so B keeps setting
        wr(adr(4, 0), 'hE0, 0, "R9 ones leave flags");
        wr(adr(4, 0), 'h00, 0, "R9 zero without read");
        rd(adr(4, 0), 0, "R9 flags kept without read");
        wr(adr(4, 0), 'h00, 0, "R9 zero after read");
        rd(adr(4, 0), 0, "R9 cleared except set wins");

        // R7 suppression: counter passes compare A in a compare write cycle
        wr(adr(0, 0), 'h0F, 0, "R7");
        rd(adr(4, 0), 0, "R7 pre read");
        wr(adr(4, 0), 'h00, 0, "R7 clear flags");
        tick_en = 2'b01; @(negedge clk);
        wr(adr(2, 0), 'h55, 0, "R7 write during match");
        tick_en = 2'b00;
        rd(adr(4, 0), 0, "R7 no flag from suppressed match");

        // R8 clear modes on channel 1
        wr(adr(3, 1), 'h09, 0, "R8");
        tick_en = 2'b10; idle(13); tick_en = 2'b00;
        rd(adr(0, 1), 0, "R8 clear on A");
        wr(adr(2, 1), 'h03, 0, "R8");
        wr(adr(3, 1), 'h11, 0, "R8");
        tick_en = 2'b10; idle(9); tick_en = 2'b00;
        rd(adr(0, 1), 0, "R8 clear on B");
        wr(adr(3, 1), 'h19, 0, "R8");
        wr(adr(0, 1), 'h00, 0, "R8");
        tick_en = 2'b10; idle(10); tick_en = 2'b00;
        rd(adr(0, 1), 0, "R8 reserved mode no clear");
        wr(adr(1, 1), 'hFF, 0, "R8");
        wr(adr(3, 1), 'h09, 0, "R8");
        wr(adr(0, 1), 'hFD, 0, "R8");
        tick_en = 2'b10; idle(5); tick_en = 2'b00;
        rd(adr(4, 1), 0, "R8 clear from FF sets no overflow");
        rd(adr(0, 1), 0, "R8 count after clear from FF");

        // R11 pin actions and B priority
        wr(adr(1, 1), 'h05, 0, "R11");
        wr(adr(4, 1), 'h03, 0, "R11 toggle on A");
        wr(adr(0, 1), 'h00, 0, "R11");
        tick_en = 2'b10; idle(20); tick_en = 2'b00;
        wr(adr(1, 1), 'h04, 0, "R11");
        wr(adr(2, 1), 'h04, 0, "R11");
        wr(adr(4, 1), 'h06, 0, "R11 B low beats A high");
        wr(adr(0, 1), 'h00, 0, "R11");
        tick_en = 2'b10; idle(12); tick_en = 2'b00;
        wr(adr(4, 1), 'h02, 0, "R11 B hold beats A high");
        tick_en = 2'b10; idle(12); tick_en = 2'b00;
        wr(adr(4, 1), 'h0E, 0, "R11 B toggle");
        tick_en = 2'b10; idle(12); tick_en = 2'b00;
        rd(adr(4, 1), 0, "R11 select fields");
        wr(adr(3, 1), 'hE1, 0, "R10 all enables");
        idle(2);

        // R1 standby returns everything to reset values
        hw_standby = 1'b1; @(negedge clk); hw_standby = 1'b0;
        for (int c = 0; c < 2; c++)
            for (int k = 0; k < 5; k++) rd(adr(k, c), 0, "R1 standby value");
        rd(adr(1, 0), 1, "R1 standby word read");
        idle(2);
        finish_run();
    end

endmodule